// File: doc/BRIEF.md
# Wide-Bus Ternary Header Locator

This block watches a 448-bit streaming data bus, one word for each cycle in which the valid strobe is high. It searches that stream for a programmable header pattern of up to 48 bits. Each pattern bit is either compared against a fixed value or ignored, so the pattern is ternary: 0, 1 or don't-care. Stream bit order is LSB-first. Word bit 0 arrives earliest, and bit 0 of a following word comes right after bit 447 of the word before it.

A header may start near the end of one word and finish in the next. For that reason the block keeps the top 47 bits of the previous word and searches them together with the current word. Every word therefore offers 448 candidate start points: the 47 saved bits plus the first 401 bits of the new word. A start point later than that in the new word is examined when the next word arrives.

The block reports the three lowest matching start offsets on a 31-bit side bus, one cycle after the word, next to a registered copy of that word. An overflow bit shows that more than three offsets matched. Pattern and care values are loaded through a separate write port.

Top module: `hdr_locator`

## Requirements
- R1: A candidate start offset matches when, for every pattern bit j whose care bit is 1, the stream bit at start+j equals pattern bit j. Pattern bits whose care bit is 0 are ignored.
- R2: For each word, candidate starts are previous-word bits 401..447 and current-word bits 0..400. The reported offset of a previous-word bit b is b-401 (0..46). The reported offset of a current-word bit b is b+47 (47..447). A header that straddles two words is found in the second of them.
- R3: Up to three matching offsets are reported in ascending order, lowest first. Slot 0 occupies hits_o[9:0], slot 1 occupies hits_o[19:10] and slot 2 occupies hits_o[29:20]. Within a slot, the top bit is the valid flag and the low 9 bits are the offset. Unused slots are all zero.
- R4: hits_o[30] is 1 exactly when more than three offsets matched in that word.
- R5: After reset, or after clr_i, the saved tail is invalid, so offsets 0..46 are not reported for the next valid word. A word that arrives together with clr_i is also treated as the first word of a new stream.
- R6: Cycles with vld_i low do not change the saved tail. A header that straddles two words separated by idle cycles is still found.
- R7: A pattern or care write with cfg_we_i applies to valid words in later cycles. A word that is valid in the same cycle as the write is compared against the previous values.
- R8: vld_o and hits_o follow a valid word by exactly one cycle, and data_o is that word. When vld_o is low, hits_o is zero.
- R9: While in reset and right after it, vld_o is 0 and hits_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Start of a new stream; invalidates the saved tail |
| cfg_we_i | input | 1 | Write strobe for pattern and care |
| cfg_pat_i | input | 48 | Pattern value bits |
| cfg_care_i | input | 48 | Per-bit compare enable (0 = don't care) |
| vld_i | input | 1 | Data word valid |
| data_i | input | 448 | Data word |
| vld_o | output | 1 | Registered word valid |
| data_o | output | 448 | Registered copy of the word |
| hits_o | output | 31 | Three offset slots plus overflow bit |

## Verification
A table of two-word streams is used to try the search. It includes:
- a full-care header placed inside the first word, which checks the offset mapping for current-word starts;
- a header at the last start bit that still fits in one word (bit 400), and one at the first bit of the second word;
- a header straddling the word boundary, which shows the saved tail is actually searched;
- four headers in one word, which separate "lowest three in order" from overflow;
- a short masked pattern and a pattern with don't-care bits in the middle, which show that care bits, not pattern length, decide the compare.

Directed cases cover the following:
- a single flipped bit, which must miss until that bit's care is cleared;
- an all-don't-care pattern, which shows where the tail window begins and ends;
- a clear between two halves of a header, and idle gaps between two halves;
- a configuration write that lands in the same cycle as a word.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int unsigned WORD_W  = 448;
  localparam int unsigned PAT_W   = 48;
  localparam int unsigned HITS    = 3;
endpackage

// File: rtl/hl_cfg_regs.sv
module hl_cfg_regs #(
  parameter int unsigned PAT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [PAT_W-1:0] care_i,
  output logic [PAT_W-1:0] pat_o,
  output logic [PAT_W-1:0] care_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_o  <= '0;
      care_o <= '1;
    end else if (we_i) begin
      pat_o  <= pat_i;
      care_o <= care_i;
    end
  end

  // R7: compare values only move on a write
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pat_o) && $stable(care_o)));
endmodule

// File: rtl/hl_tail.sv
module hl_tail #(
  parameter int unsigned WORD_W  = 448,
  parameter int unsigned CARRY_W = 47
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               vld_i,
  input  logic [WORD_W-1:0]  data_i,
  output logic [CARRY_W-1:0] tail_o,
  output logic               tail_ok_o
);
  logic tail_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_o    <= '0;
      tail_ok_q <= 1'b0;
    end else if (vld_i) begin
      tail_o    <= data_i[WORD_W-1 -: CARRY_W];
      tail_ok_q <= 1'b1;
    end else if (clr_i) begin
      tail_ok_q <= 1'b0;
    end
  end

  // a clear in the same cycle as a word makes that word a stream start
  assign tail_ok_o = tail_ok_q & ~clr_i;

  // R6: idle cycles leave the tail alone
  assert_tail_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(tail_o));
  // R5: a clear without a word invalidates the tail
  assert_tail_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !vld_i) |=> !tail_ok_q);
endmodule

// File: rtl/hl_match.sv
module hl_match #(
  parameter int unsigned WORD_W  = 448,
  parameter int unsigned PAT_W   = 48,
  localparam int unsigned CARRY_W = PAT_W - 1,
  localparam int unsigned WIN_W   = WORD_W + CARRY_W
) (
  input  logic [WORD_W-1:0]  cur_i,
  input  logic [CARRY_W-1:0] tail_i,
  input  logic               tail_ok_i,
  input  logic [PAT_W-1:0]   pat_i,
  input  logic [PAT_W-1:0]   care_i,
  output logic [WORD_W-1:0]  hit_o
);
  logic [WIN_W-1:0] win;
  assign win = {cur_i, tail_i};

  for (genvar o = 0; o < WORD_W; o++) begin : g_cmp
    logic eq;
    // masked equality: any cared bit that differs kills the match
    assign eq = ~|((win[o +: PAT_W] ^ pat_i) & care_i);
    if (o < CARRY_W) begin : g_tail
      assign hit_o[o] = eq & tail_ok_i;
    end else begin : g_cur
      assign hit_o[o] = eq;
    end
  end
endmodule

// File: rtl/hl_pick.sv
module hl_pick #(
  parameter int unsigned CAND  = 448,
  parameter int unsigned HITS  = 3,
  localparam int unsigned POS_W  = $clog2(CAND),
  localparam int unsigned SLOT_W = POS_W + 1,
  localparam int unsigned SIDE_W = HITS * SLOT_W + 1
) (
  input  logic [CAND-1:0]   hit_i,
  output logic [SIDE_W-1:0] side_o
);
  logic [CAND-1:0]  rem;
  logic [POS_W-1:0] idx;
  logic             found;

  always_comb begin
    rem    = hit_i;
    side_o = '0;
    idx    = '0;
    found  = 1'b0;
    for (int h = 0; h < int'(HITS); h++) begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < int'(CAND); i++) begin
        if (!found && rem[i]) begin
          found = 1'b1;
          idx   = POS_W'(i);
        end
      end
      if (found) begin
        rem[idx] = 1'b0;
        side_o[h*SLOT_W +: SLOT_W] = {1'b1, idx};
      end
    end
    side_o[SIDE_W-1] = |rem;
  end
endmodule

// File: rtl/hdr_locator.sv
module hdr_locator #(
  parameter int unsigned WORD_W = hl_pkg::WORD_W,
  parameter int unsigned PAT_W  = hl_pkg::PAT_W,
  parameter int unsigned HITS   = hl_pkg::HITS,
  localparam int unsigned CARRY_W = PAT_W - 1,
  localparam int unsigned POS_W   = $clog2(WORD_W),
  localparam int unsigned SLOT_W  = POS_W + 1,
  localparam int unsigned SIDE_W  = HITS * SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cfg_we_i,
  input  logic [PAT_W-1:0]  cfg_pat_i,
  input  logic [PAT_W-1:0]  cfg_care_i,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] data_o,
  output logic [SIDE_W-1:0] hits_o
);
  logic [PAT_W-1:0]   pat_q, care_q;
  logic [CARRY_W-1:0] tail_q;
  logic               tail_ok;
  logic [WORD_W-1:0]  hit_vec;
  logic [SIDE_W-1:0]  side_d;

  hl_cfg_regs #(.PAT_W(PAT_W)) u_cfg (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (cfg_we_i),
    .pat_i (cfg_pat_i), .care_i (cfg_care_i),
    .pat_o (pat_q), .care_o (care_q)
  );

  hl_tail #(.WORD_W(WORD_W), .CARRY_W(CARRY_W)) u_tail (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_i), .vld_i (vld_i),
    .data_i (data_i), .tail_o (tail_q), .tail_ok_o (tail_ok)
  );

  hl_match #(.WORD_W(WORD_W), .PAT_W(PAT_W)) u_match (
    .cur_i (data_i), .tail_i (tail_q), .tail_ok_i (tail_ok),
    .pat_i (pat_q), .care_i (care_q), .hit_o (hit_vec)
  );

  hl_pick #(.CAND(WORD_W), .HITS(HITS)) u_pick (
    .hit_i (hit_vec), .side_o (side_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      hits_o <= '0;
    end else begin
      vld_o  <= vld_i;
      hits_o <= vld_i ? side_d : '0;
      if (vld_i) data_o <= data_i;
    end
  end

  // slot views for checks
  logic             s0_v, s1_v, s2_v;
  logic [POS_W-1:0] s0_p, s1_p, s2_p;
  assign {s0_v, s0_p} = hits_o[0*SLOT_W +: SLOT_W];
  assign {s1_v, s1_p} = hits_o[1*SLOT_W +: SLOT_W];
  assign {s2_v, s2_p} = hits_o[2*SLOT_W +: SLOT_W];

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (vld_o && data_o == $past(data_i)));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (hits_o == '0));
  assert_order_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v |-> (s0_v && s0_p < s1_p));
  assert_order_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_v |-> (s1_v && s1_p < s2_p));
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hits_o[SIDE_W-1] |-> (s0_v && s1_v && s2_v));
  assert_tail_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !tail_ok) |=> (!s0_v || s0_p >= POS_W'(CARRY_W)));
  assert_offset_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_v |-> (s2_p < POS_W'(WORD_W)));
endmodule

// File: tb/hdr_locator_tb.sv
module hdr_locator_tb;
  localparam int W  = 448;
  localparam int P  = 48;
  localparam int SW = 31;
  localparam logic [47:0] PA    = 48'hA1B2C3D4E5F6;
  localparam logic [47:0] PB    = 48'h0F1E2D3C4B5A;
  localparam logic [47:0] NOISE = 48'h3C3C3C3C3C3C;

  localparam int NV = 7;
  localparam logic [47:0] V_PAT  [NV] = '{PA, PA, PA, PA, PA, 48'h00000000C35A, PA};
  localparam logic [47:0] V_CARE [NV] = '{{48{1'b1}}, {48{1'b1}}, {48{1'b1}}, {48{1'b1}},
                                          {48{1'b1}}, 48'h00000000FFFF, 48'hFFFF0000FFFF};
  localparam int V_P0 [NV] = '{100, 430, 400, 448, 460,  10, 300};
  localparam int V_P1 [NV] = '{ -1,  -1,  -1,  -1, 520, 200, 700};
  localparam int V_P2 [NV] = '{ -1,  -1,  -1,  -1, 580, 440,  -1};
  localparam int V_P3 [NV] = '{ -1,  -1,  -1,  -1, 640,  -1,  -1};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clr_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [P-1:0]  cfg_pat_i = '0;
  logic [P-1:0]  cfg_care_i = '0;
  logic          vld_i = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic          vld_o;
  logic [W-1:0]  data_o;
  logic [SW-1:0] hits_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  hdr_locator u_dut (
    .clk_i, .rst_ni, .clr_i, .cfg_we_i, .cfg_pat_i, .cfg_care_i,
    .vld_i, .data_i, .vld_o, .data_o, .hits_o
  );

  always #2 clk_i = ~clk_i;

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [30:0] slots(int a, int b, int c, bit ovf);
    logic [30:0] r;
    r = '0;
    if (a >= 0) r[9:0]   = {1'b1, 9'(a)};
    if (b >= 0) r[19:10] = {1'b1, 9'(b)};
    if (c >= 0) r[29:20] = {1'b1, 9'(c)};
    r[30] = ovf;
    return r;
  endfunction

  // brute-force reference from R1..R4
  function automatic logic [30:0] ref_hits(logic [W-1:0] prev, bit prev_ok,
                                           logic [W-1:0] cur, logic [47:0] p, logic [47:0] c);
    logic [W+P-2:0] win;
    logic [30:0]    r;
    int             n;
    bit             ok;
    win = {cur, prev[W-1:W-P+1]};
    r = '0;
    n = 0;
    for (int o = 0; o < W; o++) begin
      if (o < P - 1 && !prev_ok) continue;
      ok = 1;
      for (int j = 0; j < P; j++)
        if (c[j] && win[o+j] !== p[j]) ok = 0;
      if (ok) begin
        if (n < 3) r[n*10 +: 10] = {1'b1, 9'(o)};
        n++;
      end
    end
    r[30] = (n > 3);
    return r;
  endfunction

  task automatic put(inout logic [2*W-1:0] s, input int pos, input logic [47:0] ins);
    if (pos < 0) return;
    for (int j = 0; j < P; j++)
      if (pos + j < 2*W) s[pos+j] = ins[j];
  endtask

  task automatic send(logic [W-1:0] w);
    @(negedge clk_i);
    data_i = w;
    vld_i  = 1'b1;
    @(posedge clk_i);
    #1;
    vld_i  = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic clr_pulse();
    @(negedge clk_i);
    clr_i = 1'b1;
    @(posedge clk_i);
    #1;
    clr_i = 1'b0;
  endtask

  task automatic cfg(logic [47:0] p, logic [47:0] c);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_pat_i = p; cfg_care_i = c;
    @(posedge clk_i);
    #1;
    cfg_we_i = 1'b0;
  endtask

  initial begin
    logic [2*W-1:0] s;
    logic [47:0]    ins;
    logic [W-1:0]   wa, wb;

    #1;
    chk("R9 reset vld_o", W'(vld_o), '0);
    chk("R9 reset hits_o", W'(hits_o), '0);
    idle(3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(1);
    chk("R9 after reset hits_o", W'(hits_o), '0);

    // table of two-word streams: R1 R2 R3 R4 R8
    for (int v = 0; v < NV; v++) begin
      cfg(V_PAT[v], V_CARE[v]);
      clr_pulse();
      ins = (V_PAT[v] & V_CARE[v]) | (~V_CARE[v] & NOISE);
      s = '0;
      put(s, V_P0[v], ins);
      put(s, V_P1[v], ins);
      put(s, V_P2[v], ins);
      put(s, V_P3[v], ins);
      wa = s[W-1:0];
      wb = s[2*W-1:W];
      send(wa);
      chk($sformatf("R2 vec%0d word A hits", v), W'(hits_o),
          W'(ref_hits('0, 0, wa, V_PAT[v], V_CARE[v])));
      chk($sformatf("R8 vec%0d word A data", v), data_o, wa);
      send(wb);
      chk($sformatf("R3 vec%0d word B hits", v), W'(hits_o),
          W'(ref_hits(wa, 1, wb, V_PAT[v], V_CARE[v])));
      idle(1);
      chk($sformatf("R8 vec%0d idle quiet", v), W'({vld_o, hits_o}), '0);
    end

    // explicit expectations for key table rows
    cfg(PA, '1);
    clr_pulse();
    s = '0; put(s, 430, PA);
    send(s[W-1:0]);
    chk("R2 straddle word A none", W'(hits_o), '0);
    idle(2);
    send(s[2*W-1:W]);
    chk("R6 straddle across idle gap", W'(hits_o), W'(slots(29, -1, -1, 0)));

    // R5: clear between the two halves
    clr_pulse();
    send(s[W-1:0]);
    clr_pulse();
    send(s[2*W-1:W]);
    chk("R5 clear drops straddle", W'(hits_o), '0);

    // R4: four hits
    clr_pulse();
    s = '0; put(s, 460, PA); put(s, 520, PA); put(s, 580, PA); put(s, 640, PA);
    send(s[W-1:0]);
    send(s[2*W-1:W]);
    chk("R4 overflow four hits", W'(hits_o), W'(slots(59, 119, 179, 1)));

    // R1: one cared bit flipped, then care cleared on that bit
    clr_pulse();
    s = '0; put(s, 200, PA ^ 48'h20);
    send(s[W-1:0]);
    chk("R1 near miss", W'(hits_o), '0);
    cfg(PA, ~48'h20);
    clr_pulse();
    send(s[W-1:0]);
    chk("R1 don't-care bit ignored", W'(hits_o), W'(slots(247, -1, -1, 0)));

    // R5/R4: all don't care
    cfg('0, '0);
    clr_pulse();
    send('0);
    chk("R5 tail invalid first word", W'(hits_o), W'(slots(47, 48, 49, 1)));
    send('0);
    chk("R2 tail valid second word", W'(hits_o), W'(slots(0, 1, 2, 1)));

    // R7: write lands with the word
    cfg(PA, '1);
    clr_pulse();
    s = '0; put(s, 100, PB);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_pat_i = PB; cfg_care_i = '1;
    data_i = s[W-1:0]; vld_i = 1'b1;
    @(posedge clk_i);
    #1;
    cfg_we_i = 1'b0; vld_i = 1'b0;
    chk("R7 same-cycle write uses old pattern", W'(hits_o), '0);
    send(s[W-1:0]);
    chk("R7 new pattern on next word", W'(hits_o), W'(slots(147, -1, -1, 0)));

    // R5: clear together with a word
    cfg('0, '0);
    @(negedge clk_i);
    clr_i = 1'b1; data_i = '0; vld_i = 1'b1;
    @(posedge clk_i);
    #1;
    clr_i = 1'b0; vld_i = 1'b0;
    chk("R5 clear with word", W'(hits_o), W'(slots(47, 48, 49, 1)));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule